// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog counter that software programs over an APB-style slave port. A down-counter runs from a programmable load value. When the counter runs out for the first time, the block raises an interrupt and the count starts over. If software has not serviced the interrupt by the time the counter runs out a second time, the block drives a system reset, provided reset is enabled. The whole reset timeout is therefore two load periods. Software services the watchdog by writing the clear register. That write drops the interrupt and restarts the count.

Every configuration write is guarded by a key register. Writing the 32-bit magic key opens the block for writes. Writing any other value to the key register shuts it again. The block leaves reset in the shut state, so a stray write cannot stop or reprogram it. Reads always work.

Top module: `wdog_twostage`

## Requirements
- R1: After the synchronous reset input `rst`, the outputs and registers hold these values:
  - `irq` = 0 and `wdt_rst` = 0.
  - The key register (0xC00) reads 1, meaning locked.
  - The control register (0x008) reads 0.
  - The status register (0x014) reads 0.
  - The load register (0x000) and the count register (0x004) both read 0xFFFFFFFF.
- R2: Writing 0x1ACCE551 to address 0xC00 unlocks the block, and 0xC00 then reads 0. Writing any other value to 0xC00 locks it, and 0xC00 then reads 1. Writes to 0xC00 are accepted whether the block is locked or unlocked.
- R3: While the block is locked, writes to the load (0x000), control (0x008) and clear (0x00C) registers change nothing. The load, count, control and status values read back unchanged, and the counter does not start.
- R4: An unlocked write to 0x000 stores the value and loads it into the counter in the same clock. A read of 0x004 then returns that value while counting is stopped.
- R5: Control bit 1 enables counting. While it is set, the counter falls by exactly one per clock. Clearing bit 1 freezes the counter at its present value. Control bits 31:2 always read 0.
- R6: An expiry happens on a clock edge at which counting is enabled and the counter already holds 0. At the first expiry:
  - status bit 0 (0x014) becomes 1;
  - the counter reloads from the load register;
  - `irq` equals the status bit ANDed with control bit 1.

  With load value L, `irq` rises on the (L+1)th clock after counting starts.
- R7: An expiry that happens while the status bit is already 1 and control bit 0 is set drives `wdt_rst` to 1. `wdt_rst` stays at 1 until `rst` is applied. A clear does not drop it. With control bit 0 at 0, repeated expiries never assert `wdt_rst`.
- R8: An unlocked write of a value with bit 0 = 1 to 0x00C clears the status bit and reloads the counter from the load register. A write with bit 0 = 0 has no effect.
- R9: Read data is captured at the setup clock of an APB read and is valid during the access phase. The clear register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus port and the counter |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt: status ANDed with the count-enable bit |
| wdt_rst | output | 1 | Sticky system reset request |

## Verification
The bench counts clocks exactly to the first and second expiry. A design that is off by one in its expiry test, or that fails to reload at the first expiry, moves the `irq` or `wdt_rst` edge by a cycle and is caught.

It also covers three other error cases:
- A reset that drops on a clear would show up as a falling `wdt_rst` after the service write.
- A reset enable that is ignored would show up as `wdt_rst` firing under control value 2.
- A leaky lock would show up during the locked-write phase, which tries every guarded register. The random phase mixes good and bad keys with guarded writes, so a wrong key compare or a wrong relock shows up as a mismatch in a load, count or control read-back.

Finally, the `irq` gating is checked with status pending and counting stopped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] A_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] A_CLEAR = 12'h00C;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h014;
  localparam logic [ADDR_W-1:0] A_LOCK  = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  // control bit positions
  localparam int unsigned CB_RSTEN = 0;
  localparam int unsigned CB_RUN   = 1;

  typedef struct packed {
    logic run;
    logic rst_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic              locked,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output logic              load_wr,
  output logic [CNT_W-1:0]  load_val,
  output logic              clear_pls
);
  logic wr_acc;
  logic open_wr;

  assign wr_acc    = psel && penable && pwrite;
  assign open_wr   = wr_acc && !locked;
  assign load_wr   = open_wr && (paddr == A_LOAD);
  assign load_val  = pwdata[CNT_W-1:0];
  assign clear_pls = open_wr && (paddr == A_CLEAR) && pwdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
      load_q <= RST_LOAD;
      ctrl_q <= '0;
    end else if (wr_acc) begin
      if (paddr == A_LOCK)
        locked <= (pwdata != UNLOCK_KEY);
      if (!locked && paddr == A_LOAD)
        load_q <= pwdata[CNT_W-1:0];
      if (!locked && paddr == A_CTRL) begin
        ctrl_q.run    <= pwdata[CB_RUN];
        ctrl_q.rst_en <= pwdata[CB_RSTEN];
      end
    end
  end

  // R3
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && locked && paddr == A_CTRL) |=> $stable(ctrl_q));
  // R3
  locked_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && locked && paddr == A_LOAD) |=> $stable(load_q));
  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == A_LOCK && pwdata == UNLOCK_KEY) |=> !locked);
  // R2
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == A_LOCK && pwdata != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_LOAD = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl_q,
  input  logic [CNT_W-1:0] load_q,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear_pls,
  output logic [CNT_W-1:0] cnt_q,
  output logic             status_q,
  output logic             irq,
  output logic             wdt_rst_q
);
  logic expire;

  assign expire = ctrl_q.run && (cnt_q == '0) && !load_wr && !clear_pls;
  assign irq    = status_q && ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= RST_LOAD;
      status_q  <= 1'b0;
      wdt_rst_q <= 1'b0;
    end else begin
      if (load_wr)
        cnt_q <= load_val;
      else if (clear_pls || expire)
        cnt_q <= load_q;
      else if (ctrl_q.run)
        cnt_q <= cnt_q - 1'b1;

      if (clear_pls)
        status_q <= 1'b0;
      else if (expire)
        status_q <= 1'b1;

      if (expire && status_q && ctrl_q.rst_en)
        wdt_rst_q <= 1'b1;
    end
  end

  // R7
  rst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_q |=> wdt_rst_q);
  // R7
  rst_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_q) |-> ($past(status_q) && $past(ctrl_q.rst_en)));
  // R5
  frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !load_wr && !clear_pls) |=> $stable(cnt_q));
  // R6
  first_expiry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              locked,
  input  logic [CNT_W-1:0]  load_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  ctrl_t             ctrl_q,
  input  logic              status_q,
  output logic [DATA_W-1:0] prdata
);
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    unique case (paddr)
      A_LOAD:  rd_nxt = DATA_W'(load_q);
      A_COUNT: rd_nxt = DATA_W'(cnt_q);
      A_CTRL:  rd_nxt = DATA_W'(ctrl_q);
      A_STAT:  rd_nxt = DATA_W'(status_q);
      A_LOCK:  rd_nxt = DATA_W'(locked);
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      prdata <= '0;
    else if (psel && !penable && !pwrite)
      prdata <= rd_nxt;
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              wdt_rst
);
  logic             locked;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl_q;
  logic             load_wr;
  logic             clear_pls;
  logic             status_q;

  wdog_regfile #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .locked(locked), .load_q(load_q),
    .ctrl_q(ctrl_q), .load_wr(load_wr), .load_val(load_val),
    .clear_pls(clear_pls)
  );

  wdog_core #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_core (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .load_q(load_q),
    .load_wr(load_wr), .load_val(load_val), .clear_pls(clear_pls),
    .cnt_q(cnt_q), .status_q(status_q), .irq(irq), .wdt_rst_q(wdt_rst)
  );

  wdog_rdmux #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .locked(locked), .load_q(load_q), .cnt_q(cnt_q),
    .ctrl_q(ctrl_q), .status_q(status_q), .prdata(prdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!wdt_rst && !irq));
endmodule

// File: tb/wdog_twostage_tb.sv
module wdog_twostage_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq, wdt_rst;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  localparam logic [31:0] KEY = 32'h1ACC_E551;

  always #2 clk = ~clk;

  wdog_twostage u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
    .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a,
                        input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] key_or_junk(input logic [31:0] r);
    return r[0] ? KEY : ((r == KEY) ? ~r : r);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic        m_locked;
    logic [31:0] m_load, m_cnt;
    logic        m_rsten;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 wdt_rst", {31'b0, wdt_rst}, 32'd0);
    rd_chk("R1 lock", 12'hC00, 32'd1);
    rd_chk("R1 load", 12'h000, 32'hFFFF_FFFF);
    rd_chk("R1 count", 12'h004, 32'hFFFF_FFFF);
    rd_chk("R1 ctrl", 12'h008, 32'd0);
    rd_chk("R1 status", 12'h014, 32'd0);

    // R3 locked writes have no effect
    wr(12'h000, 32'h0000_1234);
    wr(12'h008, 32'h0000_0003);
    wr(12'h00C, 32'h0000_0001);
    repeat (4) @(negedge clk);
    rd_chk("R3 load", 12'h000, 32'hFFFF_FFFF);
    rd_chk("R3 count", 12'h004, 32'hFFFF_FFFF);
    rd_chk("R3 ctrl", 12'h008, 32'd0);

    // R2 lock key
    wr(12'hC00, 32'h1ACC_E550);
    rd_chk("R2 bad key stays locked", 12'hC00, 32'd1);
    wr(12'hC00, KEY);
    rd_chk("R2 key unlocks", 12'hC00, 32'd0);
    wr(12'hC00, 32'd0);
    rd_chk("R2 relock", 12'hC00, 32'd1);
    wr(12'hC00, KEY);
    rd_chk("R2 unlock again", 12'hC00, 32'd0);

    // R4 load write reaches counter
    wr(12'h000, 32'd77);
    rd_chk("R4 load", 12'h000, 32'd77);
    rd_chk("R4 count", 12'h004, 32'd77);

    // R5 decrement then freeze
    wr(12'h000, 32'd1000);
    wr(12'h008, 32'd2);
    wr(12'h008, 32'd0);
    rd_chk("R5 two decrements", 12'h004, 32'd998);
    repeat (5) @(negedge clk);
    rd_chk("R5 frozen", 12'h004, 32'd998);
    wr(12'h008, 32'hFFFF_FFF1);
    rd_chk("R5 reserved bits zero", 12'h008, 32'd1);

    // R6 first expiry, R7 second expiry with reset enabled
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd3);
    repeat (5) @(negedge clk);
    check("R6 irq before expiry", {31'b0, irq}, 32'd0);
    @(negedge clk);
    check("R6 irq at first expiry", {31'b0, irq}, 32'd1);
    repeat (5) @(negedge clk);
    check("R7 no reset before second expiry", {31'b0, wdt_rst}, 32'd0);
    @(negedge clk);
    check("R7 reset at second expiry", {31'b0, wdt_rst}, 32'd1);
    repeat (7) @(negedge clk);
    check("R7 reset sticky", {31'b0, wdt_rst}, 32'd1);
    wr(12'h00C, 32'd1);
    check("R7 clear keeps reset", {31'b0, wdt_rst}, 32'd1);
    check("R8 clear drops irq", {31'b0, irq}, 32'd0);
    do_reset();
    check("R7 reset input drops wdt_rst", {31'b0, wdt_rst}, 32'd0);
    rd_chk("R1 locked after reset", 12'hC00, 32'd1);

    // R7 reset disabled: expiries never reset
    wr(12'hC00, KEY);
    wr(12'h000, 32'd4);
    wr(12'h008, 32'd2);
    repeat (20) @(negedge clk);
    check("R7 no reset when disabled", {31'b0, wdt_rst}, 32'd0);
    check("R6 irq pending", {31'b0, irq}, 32'd1);
    rd_chk("R6 status", 12'h014, 32'd1);

    // R8 clear semantics
    wr(12'h00C, 32'h0000_0002);
    rd_chk("R8 bit0 zero no clear", 12'h014, 32'd1);
    wr(12'h008, 32'd0);
    check("R6 irq gated by run bit", {31'b0, irq}, 32'd0);
    rd_chk("R8 status before clear", 12'h014, 32'd1);
    wr(12'h00C, 32'd1);
    rd_chk("R8 status cleared", 12'h014, 32'd0);
    rd_chk("R8 counter reloaded", 12'h004, 32'd4);

    // R9 unmapped and clear reads
    rd_chk("R9 unmapped", 12'h010, 32'd0);
    rd_chk("R9 clear reads zero", 12'h00C, 32'd0);

    // random mix, counter kept frozen (R3, R2, R4, R8)
    m_locked = 1'b0; m_load = 32'd4; m_cnt = 32'd4; m_rsten = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r, d;
      r = $urandom % 6;
      d = $urandom;
      case (r)
        0: begin
          d = key_or_junk(d);
          wr(12'hC00, d);
          m_locked = (d != KEY);
        end
        1: begin
          wr(12'h000, d);
          if (!m_locked) begin m_load = d; m_cnt = d; end
        end
        2: begin
          d = d & ~32'd2;
          wr(12'h008, d);
          if (!m_locked) m_rsten = d[0];
        end
        3: begin
          wr(12'h00C, d);
          if (!m_locked && d[0]) m_cnt = m_load;
        end
        default: begin
          case ($urandom % 4)
            0: rd_chk("R3 rand load", 12'h000, m_load);
            1: rd_chk("R3 rand count", 12'h004, m_cnt);
            2: rd_chk("R3 rand ctrl", 12'h008, {31'b0, m_rsten});
            default: rd_chk("R2 rand lock", 12'hC00, {31'b0, m_locked});
          endcase
        end
      endcase
    end
    check("R7 rand no reset", {31'b0, wdt_rst}, 32'd0);

    summary();
    $finish;
  end
endmodule